// File: doc/BRIEF.md
# Rate-Dependent Symbol Boundary Tagger

This block sits after a packet builder in an OFDM transmit chain. It accepts a serial stream of payload bits and cuts it into symbols whose bit count depends on a 3-bit rate index. Every output sample carries its own tags. Two tags mark the sample's position: the opening sample and the closing sample of its symbol. Three tags describe the whole symbol: whether it is the first one, whether it is the last one, and which rate frames it. Downstream stages can therefore follow the symbol structure from the tags alone, without keeping a size table or counting samples.

A packet begins with a one-cycle start pulse that carries the packet length in bits. The length covers every bit taken from the input, including the header symbol. The opening symbol always uses the lowest rate. Each later symbol takes its rate from the rate input, sampled at the boundary before it. The symbol in which the running bit count reaches the length is flagged as the last one. Its remaining positions are filled with zeros while the input is held off.

Both the bit input and the tagged output use a valid/ready handshake. The output is a single register stage.

Top module: `sym_boundary_tagger`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid_o` and `in_ready_o` are both 0.
- R2: The number of samples in a symbol follows its rate index: 0→24, 1→36, 2→48, 3→72, 4→96, 5→144, 6→192, 7→216.
- R3: `out_sos_o` is 1 only on the first sample of a symbol, and `out_eos_o` is 1 only on the last sample of a symbol.
- R4: `out_first_o`, `out_last_o` and `out_rate_o` keep the same value on every sample of a symbol.
- R5: The first symbol of a packet has `out_first_o` = 1 and `out_rate_o` = 0, whatever value `rate_i` has. Every later symbol has `out_first_o` = 0.
- R6: `rate_i` is sampled only when the last sample of the previous symbol is taken. A change of `rate_i` in the middle of a symbol takes effect from the following symbol.
- R7: `out_last_o` is 1 on the symbol in which the count of accepted input bits reaches `len_i`. Positions after bit `len_i` are output as 0 while `in_ready_o` stays 0. After that symbol the block is idle, and no sample is output until the next start.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, every output holds its value into the next cycle and no sample is lost.
- R9: A start pulse with `len_i` = 0 is ignored: no sample is output and `in_ready_o` stays 0.
- R10: Accepted input bits appear on `out_bit_o` unchanged and in their arrival order.
- R11: A start pulse while a packet is in progress has no effect on that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle packet start, honoured only when idle |
| len_i | input | LEN_W | Packet length in bits, read with `start_i` |
| rate_i | input | 3 | Rate index for the next payload symbol |
| in_valid_i | input | 1 | Input bit valid |
| in_ready_o | output | 1 | Block accepts the input bit |
| in_bit_i | input | 1 | Serial input bit |
| out_valid_o | output | 1 | Tagged sample valid |
| out_ready_i | input | 1 | Consumer accepts the sample |
| out_bit_o | output | 1 | Output data bit (0 in padding) |
| out_sos_o | output | 1 | First sample of the symbol |
| out_eos_o | output | 1 | Last sample of the symbol |
| out_first_o | output | 1 | Sample belongs to the packet's first symbol |
| out_last_o | output | 1 | Sample belongs to the packet's last symbol |
| out_rate_o | output | 3 | Rate index of the symbol |

## Verification
A wrong position counter or a stale symbol size shows up on the first symbol that is affected. The closing tag lands on the wrong sample and the next opening tag is missing, so the fault is visible within one symbol, at most 216 samples. A wrong length or bit count shows in three ways: the last-symbol flag sits on the wrong symbol, padding zeros replace real bits (or the reverse), or the number of symbols in the packet is wrong. All of these are seen by the end of the packet. A fault in the hold logic under backpressure changes an output while it is stalled, and the bench detects that in the very next cycle.

// File: rtl/sym_tag_pkg.sv
package sym_tag_pkg;

    localparam int RATE_W    = 3;
    localparam int NUM_RATES = 1 << RATE_W;

    typedef logic [RATE_W-1:0] rate_t;

    // One sample of the tagged stream.
    typedef struct packed {
        logic  data;
        logic  sos;
        logic  eos;
        logic  first;
        logic  last;
        rate_t rate;
    } tag_sample_t;

    // Bits carried by one symbol for each rate index.
    function automatic int unsigned sym_bits(rate_t r);
        case (r)
            3'd0:    sym_bits = 24;
            3'd1:    sym_bits = 36;
            3'd2:    sym_bits = 48;
            3'd3:    sym_bits = 72;
            3'd4:    sym_bits = 96;
            3'd5:    sym_bits = 144;
            3'd6:    sym_bits = 192;
            default: sym_bits = 216;
        endcase
    endfunction

endpackage

// File: rtl/sym_size_lut.sv
module sym_size_lut
    import sym_tag_pkg::*;
#(
    parameter int SIZE_W = 8
) (
    input  rate_t             rate_i,
    output logic [SIZE_W-1:0] size_o
);

    logic [SIZE_W-1:0] size_tab [NUM_RATES];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_tab
        assign size_tab[g] = SIZE_W'(sym_bits(rate_t'(g)));
    end

    assign size_o = size_tab[rate_i];

endmodule

// File: rtl/sym_tag_ctrl.sv
module sym_tag_ctrl
    import sym_tag_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int SIZE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  rate_t            rate_i,
    input  logic             in_valid_i,
    input  logic             in_bit_i,
    input  logic             can_load_i,
    output logic             in_ready_o,
    output logic             prod_valid_o,
    output tag_sample_t      prod_o
);

    localparam int CNT_W = LEN_W + 1;
    localparam int SUM_W = LEN_W + 2;

    typedef struct packed {
        logic              busy;
        logic [LEN_W-1:0]  len;
        logic [CNT_W-1:0]  consumed;
        logic [SIZE_W-1:0] pos;
        logic [SIZE_W-1:0] size;
        rate_t             rate;
        logic              first;
        logic              last;
    } ctrl_t;

    ctrl_t st_d, st_q;

    rate_t             lut_rate;
    logic [SIZE_W-1:0] lut_size;

    // Idle: the header symbol always uses rate 0. Busy: next symbol's rate.
    assign lut_rate = st_q.busy ? rate_i : '0;

    sym_size_lut #(.SIZE_W(SIZE_W)) i_size_lut (
        .rate_i (lut_rate),
        .size_o (lut_size)
    );

    logic             pad;
    logic             at_end;
    logic             fire;
    logic [CNT_W-1:0] consumed_n;

    always_comb begin
        st_d   = st_q;
        pad    = st_q.consumed >= CNT_W'(st_q.len);
        at_end = st_q.pos == (st_q.size - 1'b1);

        prod_valid_o = st_q.busy && (pad || in_valid_i);
        fire         = prod_valid_o && can_load_i;
        in_ready_o   = st_q.busy && !pad && can_load_i;

        prod_o.data  = pad ? 1'b0 : in_bit_i;
        prod_o.sos   = st_q.pos == '0;
        prod_o.eos   = at_end;
        prod_o.first = st_q.first;
        prod_o.last  = st_q.last;
        prod_o.rate  = st_q.rate;

        consumed_n = st_q.consumed + CNT_W'(!pad);

        if (!st_q.busy) begin
            if (start_i && (len_i != '0)) begin
                st_d.busy     = 1'b1;
                st_d.len      = len_i;
                st_d.consumed = '0;
                st_d.pos      = '0;
                st_d.size     = lut_size;
                st_d.rate     = '0;
                st_d.first    = 1'b1;
                st_d.last     = SUM_W'(lut_size) >= SUM_W'(len_i);
            end
        end else if (fire) begin
            st_d.consumed = consumed_n;
            if (at_end) begin
                if (st_q.last) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.pos   = '0;
                    st_d.size  = lut_size;
                    st_d.rate  = rate_i;
                    st_d.first = 1'b0;
                    st_d.last  = (SUM_W'(consumed_n) + SUM_W'(lut_size))
                                 >= SUM_W'(st_q.len);
                end
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sym_out_stage.sv
module sym_out_stage
    import sym_tag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        prod_valid_i,
    input  tag_sample_t prod_i,
    input  logic        out_ready_i,
    output logic        can_load_o,
    output logic        out_valid_o,
    output tag_sample_t out_o
);

    typedef struct packed {
        logic        valid;
        tag_sample_t smp;
    } stage_t;

    stage_t stg_d, stg_q;

    always_comb begin
        stg_d      = stg_q;
        can_load_o = !stg_q.valid || out_ready_i;
        if (can_load_o) begin
            stg_d.valid = prod_valid_i;
            if (prod_valid_i) begin
                stg_d.smp = prod_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign out_valid_o = stg_q.valid;
    assign out_o       = stg_q.smp;

endmodule

// File: rtl/sym_boundary_tagger.sv
module sym_boundary_tagger
    import sym_tag_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int SIZE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [2:0]       rate_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic             in_bit_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic             out_bit_o,
    output logic             out_sos_o,
    output logic             out_eos_o,
    output logic             out_first_o,
    output logic             out_last_o,
    output logic [2:0]       out_rate_o
);

    logic        can_load;
    logic        prod_valid;
    tag_sample_t prod;
    tag_sample_t out_smp;

    sym_tag_ctrl #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .len_i        (len_i),
        .rate_i       (rate_t'(rate_i)),
        .in_valid_i   (in_valid_i),
        .in_bit_i     (in_bit_i),
        .can_load_i   (can_load),
        .in_ready_o   (in_ready_o),
        .prod_valid_o (prod_valid),
        .prod_o       (prod)
    );

    sym_out_stage i_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .prod_valid_i (prod_valid),
        .prod_i       (prod),
        .out_ready_i  (out_ready_i),
        .can_load_o   (can_load),
        .out_valid_o  (out_valid_o),
        .out_o        (out_smp)
    );

    assign out_bit_o   = out_smp.data;
    assign out_sos_o   = out_smp.sos;
    assign out_eos_o   = out_smp.eos;
    assign out_first_o = out_smp.first;
    assign out_last_o  = out_smp.last;
    assign out_rate_o  = out_smp.rate;

endmodule

// File: rtl/sym_boundary_tagger_chk.sv
module sym_boundary_tagger_chk
    import sym_tag_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid_o,
    input logic       out_ready_i,
    input logic       out_bit_o,
    input logic       out_sos_o,
    input logic       out_eos_o,
    input logic       out_first_o,
    input logic       out_last_o,
    input logic [2:0] out_rate_o
);

    logic [7:0] cnt_q;
    logic       pf_q;
    logic       pl_q;
    logic [2:0] pr_q;
    logic       xfer;

    assign xfer = out_valid_o && out_ready_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pf_q  <= 1'b0;
            pl_q  <= 1'b0;
            pr_q  <= '0;
        end else if (xfer) begin
            cnt_q <= out_eos_o ? 8'd0 : cnt_q + 8'd1;
            pf_q  <= out_first_o;
            pl_q  <= out_last_o;
            pr_q  <= out_rate_o;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_bit_o)
        && $stable(out_sos_o) && $stable(out_eos_o) && $stable(out_first_o)
        && $stable(out_last_o) && $stable(out_rate_o)); // R8

    AST_SOS_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && (cnt_q == 8'd0) |-> out_sos_o); // R3

    AST_NO_SOS_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && (cnt_q != 8'd0) |-> !out_sos_o); // R3

    AST_TAGS_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && (cnt_q != 8'd0) |-> (out_first_o == pf_q)
        && (out_last_o == pl_q) && (out_rate_o == pr_q)); // R4

    AST_EOS_AT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> out_eos_o == (int'(cnt_q) == int'(sym_bits(rate_t'(out_rate_o))) - 1)); // R2

    AST_FIRST_RATE0: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_first_o |-> out_rate_o == 3'd0); // R5

endmodule

bind sym_boundary_tagger sym_boundary_tagger_chk i_chk (.*);

// File: tb/test_sym_boundary_tagger.sv
module test_sym_boundary_tagger;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic [2:0]       rate_i = '0;
    logic             in_valid_i = 1'b0;
    logic             in_ready_o;
    logic             in_bit_i = 1'b0;
    logic             out_valid_o;
    logic             out_ready_i = 1'b0;
    logic             out_bit_o;
    logic             out_sos_o;
    logic             out_eos_o;
    logic             out_first_o;
    logic             out_last_o;
    logic [2:0]       out_rate_o;

    int checks = 0;
    int errors = 0;
    int sched [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    sym_boundary_tagger #(.LEN_W(LEN_W)) i_sym_boundary_tagger (.*);

    function automatic int exp_size(int r);
        case (r)
            0: return 24;  1: return 36;  2: return 48;  3: return 72;
            4: return 96;  5: return 144; 6: return 192; default: return 216;
        endcase
    endfunction

    function automatic logic pat(int g);
        return 1'((g * 7 + g / 3) ^ (g >> 2));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_pkt(input int len);
        @(negedge clk);
        start_i = 1'b1;
        len_i   = LEN_W'(len);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic idle_check(input string req, input int ncyc);
        bit bad = 0;
        out_ready_i = 1'b1;
        in_valid_i  = 1'b1;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            #1;
            if (out_valid_o || in_ready_o) bad = 1;
        end
        chk(!bad, req, int'(bad), 0);
        in_valid_i = 1'b0;
    endtask

    // Runs one packet and checks every output sample against the requirements.
    task automatic run_pkt(input int len, input bit stall, input bit busy_start, input string name);
        int nsym = 0, cum = 0;
        int j = 0, p = 0, scum = 0, r = 0, sz = 24;
        int idx = 0, cyc = 0, got_sym = 0;
        bit done = 0, hold_pend = 0, pad_bad = 0, held_bad = 0;
        logic [7:0] held;
        logic exp_last;
        while (cum < len) begin
            cum += exp_size(nsym == 0 ? 0 : sched[nsym]);
            nsym++;
        end
        rate_i = 3'(sched[0]);
        start_pkt(len);
        while (!done && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            out_ready_i = stall ? ((cyc % 3) != 0) : 1'b1;
            in_valid_i  = stall ? ((cyc % 5) != 2) : 1'b1;
            in_bit_i    = pat(idx);
            start_i     = busy_start && (cyc == 40);
            len_i       = busy_start ? LEN_W'(5) : len_i;
            #1;
            if (hold_pend) begin
                if (!out_valid_o || held != {out_bit_o, out_sos_o, out_eos_o,
                        out_first_o, out_last_o, out_rate_o}) held_bad = 1;
            end
            hold_pend = 0;
            if (out_valid_o && !out_ready_i) begin
                held = {out_bit_o, out_sos_o, out_eos_o, out_first_o, out_last_o, out_rate_o};
                hold_pend = 1;
            end
            if (out_valid_o && out_ready_i) begin
                exp_last = (scum + sz) >= len;
                chk(out_sos_o == (p == 0), {name, " R3 sos"}, int'(out_sos_o), int'(p == 0));
                chk(out_eos_o == (p == sz - 1), {name, " R2 eos position"}, int'(out_eos_o), int'(p == sz - 1));
                chk(out_first_o == (j == 0), {name, " R5 first flag"}, int'(out_first_o), int'(j == 0));
                chk(int'(out_rate_o) == r, {name, " R4 R6 rate tag"}, int'(out_rate_o), r);
                chk(out_last_o == exp_last, {name, " R7 last flag"}, int'(out_last_o), int'(exp_last));
                chk(out_bit_o == ((scum + p) < len ? pat(scum + p) : 1'b0),
                    {name, " R10 data bit"}, int'(out_bit_o),
                    int'((scum + p) < len ? pat(scum + p) : 1'b0));
                if (p == 5) rate_i = 3'(sched[j + 1]);
                if (p == sz - 1) begin
                    got_sym++;
                    if (exp_last) done = 1;
                    scum += sz;
                    j++;
                    p  = 0;
                    r  = sched[j];
                    sz = exp_size(r);
                end else begin
                    p++;
                end
            end
            if (in_valid_i && in_ready_o) begin
                if (idx >= len) pad_bad = 1;
                idx++;
            end
        end
        start_i = 1'b0;
        chk(done, {name, " packet completed"}, int'(done), 1);
        chk(got_sym == nsym, {name, " R7 R11 symbol count"}, got_sym, nsym);
        chk(idx == len, {name, " R7 bits consumed"}, idx, len);
        chk(!pad_bad, {name, " R7 no input during padding"}, int'(pad_bad), 0);
        if (stall) chk(!held_bad, {name, " R8 hold under backpressure"}, int'(held_bad), 0);
        idle_check({name, " R7 idle after last symbol"}, 12);
    endtask

    task automatic fill_sched(input int v);
        for (int i = 0; i < 16; i++) sched[i] = v;
    endtask

    task automatic t_reset();
        #1;
        chk(!out_valid_o && !in_ready_o, "R1 during reset", int'({out_valid_o, in_ready_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!out_valid_o && !in_ready_o, "R1 after reset", int'({out_valid_o, in_ready_o}), 0);
    endtask

    task automatic t_short_pad();
        fill_sched(5);
        run_pkt(10, 1'b0, 1'b0, "short_pad");
    endtask

    task automatic t_exact_fit();
        fill_sched(2);
        run_pkt(24, 1'b0, 1'b0, "exact_fit");
    endtask

    task automatic t_spill();
        fill_sched(7);
        run_pkt(25, 1'b0, 1'b0, "spill");
    endtask

    task automatic t_all_rates();
        fill_sched(0);
        sched[0] = 7;
        for (int i = 1; i < 8; i++) sched[i] = i;
        sched[8] = 0;
        run_pkt(838, 1'b1, 1'b0, "all_rates");
    endtask

    task automatic t_busy_start();
        fill_sched(3);
        run_pkt(100, 1'b0, 1'b1, "busy_start");
    endtask

    task automatic t_zero_len();
        start_pkt(0);
        idle_check("R9 zero length ignored", 30);
        fill_sched(4);
        run_pkt(48, 1'b1, 1'b0, "after_zero");
    endtask

    initial begin
        t_reset();
        t_short_pad();
        t_exact_fit();
        t_spill();
        t_all_rates();
        t_busy_start();
        t_zero_len();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule